// File: doc/BRIEF.md
# Configurable Pin Cell with Mux Chaining

This block is a single programmable pin cell for a routing fabric. A small dynamic multiplexer picks one of four legs with two select lines. Each leg can take its local data line, the mux output of one of the two neighbouring cells on either side, or a constant 0. Cells can therefore be cascaded: four cells each build a 4:1 selection, and a fifth cell merges their outputs into one 16:1 selection.

One storage element serves the cell. It can be an edge register or a flow-through latch. It can sit in the outbound path, where it is loaded from the mux and drives the pad, or in the inbound path, where it is loaded from the pad input and drives the routing return. A bypass gives a purely combinational outbound path.

The outbound value passes through a polarity stage and can be overridden by a fixed level. The pad enable follows the per-cell enable, with an option that makes the cell drive lows only, so that an external pull-up gives open-drain behaviour. The storage clock polarity is programmable, and loading is gated by a clock enable.

Top module: `pio_cell`

## Requirements
- R1: With every leg source code at 0, `mux_o` equals `data_i[sel_i]`, where `sel_i` is a binary leg index.
- R2: The 3-bit source code of leg g sits at `cfg_leg_src_i[3*g+2:3*g]`. The codes mean: 0 selects `data_i[g]`, 1 selects `up_i[0]` (cell N-1), 2 selects `up_i[1]` (cell N-2), 3 selects `dn_i[0]` (cell N+1), 4 selects `dn_i[1]` (cell N+2), and 5 to 7 select a constant 0.
- R3: In register mode (`cfg_latch_i`=0) with `cfg_clk_inv_i`=0 and `clk_en_i`=1, the storage loads on the rising edge of `clk_i`. The pad shows the new value only after that edge.
- R4: When `clk_en_i`=0, the storage keeps its value across clock edges.
- R5: With `cfg_clk_inv_i`=1, the register loads on the falling edge of `clk_i`.
- R6: In latch mode the storage is transparent while the polarity-adjusted clock is high and `clk_en_i`=1. At all other times it holds.
- R7: With `cfg_path_in_i`=1, the storage loads from `pin_i` and drives `route_o`, while the pad takes the mux output combinationally.
- R8: With `cfg_bypass_i`=1 and `cfg_path_in_i`=0, the pad follows the mux output combinationally.
- R9: `cfg_out_inv_i`=1 inverts the value driven on `pad_o`.
- R10: `cfg_const_en_i`=1 forces the pad value to `cfg_const_val_i`, whatever the data path holds.
- R11: `pad_oe_o` is 0 whenever `oe_i`=0. With `cfg_open_drain_i`=1, `pad_o` is 0 and `pad_oe_o` is 1 only when the cell value is 0.
- R12: `rst_ni`=0 clears the storage to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Storage clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Storage load enable |
| data_i | input | 4 | Local mux data lines |
| sel_i | input | 2 | Dynamic leg select |
| up_i | input | 2 | Mux outputs of cells N-1, N-2 |
| dn_i | input | 2 | Mux outputs of cells N+1, N+2 |
| pin_i | input | 1 | Value seen at the pad |
| oe_i | input | 1 | Per-cell output enable |
| cfg_leg_src_i | input | 12 | Leg source codes, 3 bits per leg |
| cfg_path_in_i | input | 1 | 1: storage in inbound path |
| cfg_latch_i | input | 1 | 1: latch, 0: register |
| cfg_bypass_i | input | 1 | 1: bypass storage |
| cfg_clk_inv_i | input | 1 | 1: invert storage clock |
| cfg_out_inv_i | input | 1 | 1: active-low pad value |
| cfg_const_en_i | input | 1 | 1: force fixed pad level |
| cfg_const_val_i | input | 1 | Fixed pad level |
| cfg_open_drain_i | input | 1 | 1: drive lows only |
| pad_o | output | 1 | Pad data |
| pad_oe_o | output | 1 | Pad drive enable |
| route_o | output | 1 | Value returned to routing |
| mux_o | output | 1 | This cell's mux output, for neighbours |

## Verification
The chaining legs are driven so that the neighbour bit and the local data bit disagree. A wrong source decode, or swapped up and down neighbours, then shows up as a wrong `mux_o`. The bench samples the pad just before and just after the active edge, including a falling-edge capture. A design that loaded one cycle early, ignored the clock enable, or ignored clock inversion would show a stale or premature value there. Latch mode is checked during the high phase and the low phase of the clock, which separates a transparent latch from a register. Open-drain, constant override and mid-cycle reset are checked at the pad pins, where a design that drove highs or waited for an edge to clear would differ.

// File: rtl/pio_cell_pkg.sv
package pio_cell_pkg;
  localparam int unsigned SRC_DATA = 0;

  typedef enum logic {
    STORE_REG   = 1'b0,
    STORE_LATCH = 1'b1
  } store_mode_e;
endpackage

// File: rtl/pio_leg_mux.sv
module pio_leg_mux #(
  parameter int unsigned LEGS  = 4,
  parameter int unsigned NBR   = 2,
  parameter int unsigned SEL_W = $clog2(LEGS),
  parameter int unsigned SRC_W = $clog2(2 * NBR + 2)
) (
  input  logic [LEGS-1:0]       data_i,
  input  logic [NBR-1:0]        up_i,
  input  logic [NBR-1:0]        dn_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [LEGS*SRC_W-1:0] src_i,
  output logic                  mux_o
);
  import pio_cell_pkg::*;

  logic [LEGS-1:0] leg;

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    logic [SRC_W-1:0] code;
    assign code = src_i[g*SRC_W +: SRC_W];
    always_comb begin
      leg[g] = 1'b0;
      if (code == SRC_W'(SRC_DATA)) leg[g] = data_i[g];
      for (int n = 0; n < NBR; n++) begin
        if (code == SRC_W'(n + 1))       leg[g] = up_i[n];
        if (code == SRC_W'(NBR + 1 + n)) leg[g] = dn_i[n];
      end
    end
  end

  assign mux_o = leg[sel_i];
endmodule

// File: rtl/pio_store.sv
module pio_store (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_inv_i,
  input  logic clk_en_i,
  input  logic latch_i,
  input  logic d_i,
  output logic q_o
);
  import pio_cell_pkg::*;

  logic clk_act;
  logic q_reg, q_lat;

  assign clk_act = clk_i ^ clk_inv_i;

  always_ff @(posedge clk_act or negedge rst_ni) begin
    if (!rst_ni)       q_reg <= 1'b0;
    else if (clk_en_i) q_reg <= d_i;
  end

  always_latch begin
    if (!rst_ni)                  q_lat = 1'b0;
    else if (clk_act && clk_en_i) q_lat = d_i;
  end

  assign q_o = (store_mode_e'(latch_i) == STORE_LATCH) ? q_lat : q_reg;
endmodule

// File: rtl/pio_drive.sv
module pio_drive (
  input  logic val_i,
  input  logic out_inv_i,
  input  logic const_en_i,
  input  logic const_val_i,
  input  logic open_drain_i,
  input  logic oe_i,
  output logic pad_o,
  output logic pad_oe_o
);
  logic lvl;

  assign lvl      = const_en_i ? const_val_i : (val_i ^ out_inv_i);
  // open drain: only a low is ever driven
  assign pad_o    = open_drain_i ? 1'b0 : lvl;
  assign pad_oe_o = oe_i & (open_drain_i ? ~lvl : 1'b1);
endmodule

// File: rtl/pio_cell.sv
module pio_cell #(
  parameter int unsigned LEGS  = 4,
  parameter int unsigned NBR   = 2,
  localparam int unsigned SEL_W = $clog2(LEGS),
  localparam int unsigned SRC_W = $clog2(2 * NBR + 2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clk_en_i,
  input  logic [LEGS-1:0]       data_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [NBR-1:0]        up_i,
  input  logic [NBR-1:0]        dn_i,
  input  logic                  pin_i,
  input  logic                  oe_i,
  input  logic [LEGS*SRC_W-1:0] cfg_leg_src_i,
  input  logic                  cfg_path_in_i,
  input  logic                  cfg_latch_i,
  input  logic                  cfg_bypass_i,
  input  logic                  cfg_clk_inv_i,
  input  logic                  cfg_out_inv_i,
  input  logic                  cfg_const_en_i,
  input  logic                  cfg_const_val_i,
  input  logic                  cfg_open_drain_i,
  output logic                  pad_o,
  output logic                  pad_oe_o,
  output logic                  route_o,
  output logic                  mux_o
);
  logic mux_val, store_d, store_q, out_val;

  pio_leg_mux #(.LEGS(LEGS), .NBR(NBR), .SEL_W(SEL_W), .SRC_W(SRC_W)) i_mux (
    .data_i (data_i),
    .up_i   (up_i),
    .dn_i   (dn_i),
    .sel_i  (sel_i),
    .src_i  (cfg_leg_src_i),
    .mux_o  (mux_val)
  );

  assign store_d = cfg_path_in_i ? pin_i : mux_val;

  pio_store i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_inv_i (cfg_clk_inv_i),
    .clk_en_i  (clk_en_i),
    .latch_i   (cfg_latch_i),
    .d_i       (store_d),
    .q_o       (store_q)
  );

  assign out_val = (cfg_path_in_i || cfg_bypass_i) ? mux_val : store_q;
  assign route_o = (cfg_path_in_i && !cfg_bypass_i) ? store_q : pin_i;
  assign mux_o   = mux_val;

  pio_drive i_drive (
    .val_i        (out_val),
    .out_inv_i    (cfg_out_inv_i),
    .const_en_i   (cfg_const_en_i),
    .const_val_i  (cfg_const_val_i),
    .open_drain_i (cfg_open_drain_i),
    .oe_i         (oe_i),
    .pad_o        (pad_o),
    .pad_oe_o     (pad_oe_o)
  );

  assert_mux_leg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_leg_src_i == '0) |-> (mux_o == data_i[sel_i]));

  assert_reg_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_latch_i && !cfg_clk_inv_i && clk_en_i) |=>
    (cfg_latch_i || cfg_clk_inv_i || store_q == $past(store_d)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_latch_i && !cfg_clk_inv_i && !clk_en_i) |=>
    (cfg_latch_i || cfg_clk_inv_i || $stable(store_q)));

  assert_const_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_const_en_i && !cfg_open_drain_i) |-> (pad_o == cfg_const_val_i));

  assert_oe_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !pad_oe_o);

  assert_open_drain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_open_drain_i |-> !pad_o);
endmodule

// File: tb/test_pio_cell.sv
module test_pio_cell;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {src[22:11], data[10:7], up[6:5], dn[4:3], sel[2:1], exp[0]}
  localparam logic [22:0] VEC [NV] = '{
    {12'o0000, 4'b0100, 2'b00, 2'b00, 2'd2, 1'b1},
    {12'o0000, 4'b0100, 2'b00, 2'b00, 2'd1, 1'b0},
    {12'o1000, 4'b0000, 2'b01, 2'b00, 2'd3, 1'b1},
    {12'o0002, 4'b0000, 2'b10, 2'b00, 2'd0, 1'b1},
    {12'o0030, 4'b0000, 2'b00, 2'b01, 2'd1, 1'b1},
    {12'o0400, 4'b0100, 2'b11, 2'b01, 2'd2, 1'b0},
    {12'o0600, 4'b0100, 2'b11, 2'b11, 2'd2, 1'b0},
    {12'o1000, 4'b1000, 2'b10, 2'b00, 2'd3, 1'b0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b1, clk_en_i = 1'b0;
  logic [3:0] data_i = '0;
  logic [1:0] sel_i = '0, up_i = '0, dn_i = '0;
  logic pin_i = 1'b1, oe_i = 1'b1;
  logic [11:0] cfg_leg_src_i = '0;
  logic cfg_path_in_i = 0, cfg_latch_i = 0, cfg_bypass_i = 0, cfg_clk_inv_i = 0;
  logic cfg_out_inv_i = 0, cfg_const_en_i = 0, cfg_const_val_i = 0, cfg_open_drain_i = 0;
  logic pad_o, pad_oe_o, route_o, mux_o;
  int checks = 0, failures = 0;

  pio_cell i_pio_cell (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // move to 2 time units after the next rising edge
  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    step(); step();
    #4;
    chk("R12 reset pad", pad_o, 1'b0);
    chk("R11 oe follows", pad_oe_o, 1'b1);
    step();
    rst_ni = 1'b1;

    // table walk: mux legs and chaining, shown via bypass on pad
    cfg_bypass_i = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {cfg_leg_src_i, data_i, up_i, dn_i, sel_i} = VEC[i][22:1];
      #1;
      chk("R1/R2 mux", mux_o, VEC[i][0]);
      chk("R8 bypass pad", pad_o, VEC[i][0]);
      #1;
    end

    // R3 register capture at rising edge
    step();
    cfg_bypass_i = 0; cfg_leg_src_i = '0; sel_i = 0; data_i = 4'b0001; clk_en_i = 1;
    #6 chk("R3 before edge", pad_o, 1'b0);
    step();
    chk("R3 after edge", pad_o, 1'b1);
    data_i = 4'b0000; clk_en_i = 0;
    step();
    chk("R4 hold no enable", pad_o, 1'b1);
    // R5 falling edge capture
    cfg_clk_inv_i = 1; clk_en_i = 1;
    #2 chk("R5 before fall", pad_o, 1'b1);
    #4 chk("R5 after fall", pad_o, 1'b0);
    step();
    cfg_clk_inv_i = 0;

    // R6 latch
    step();
    cfg_latch_i = 1; data_i = 4'b0001;
    #1 chk("R6 transparent high", pad_o, 1'b1);
    #4 data_i = 4'b0000;
    #1 chk("R6 hold low phase", pad_o, 1'b1);
    step();
    chk("R6 transparent again", pad_o, 1'b0);
    clk_en_i = 0; data_i = 4'b0001;
    #1 chk("R6 enable low holds", pad_o, 1'b0);
    step();
    cfg_latch_i = 0; clk_en_i = 1;

    // R7 inbound path
    cfg_path_in_i = 1; pin_i = 1; data_i = 4'b0001;
    #1 chk("R7 pad from mux", pad_o, 1'b1);
    step();
    chk("R7 route loaded", route_o, 1'b1);
    pin_i = 0; data_i = 4'b0000;
    #1 chk("R7 route held", route_o, 1'b1);
    chk("R7 pad from mux low", pad_o, 1'b0);
    step();
    chk("R7 route reloaded", route_o, 1'b0);

    // R9 inversion
    cfg_path_in_i = 0; cfg_bypass_i = 1; cfg_out_inv_i = 1; data_i = 4'b0001;
    #1 chk("R9 invert high", pad_o, 1'b0);
    data_i = 4'b0000;
    #1 chk("R9 invert low", pad_o, 1'b1);
    cfg_out_inv_i = 0;

    // R10 constant level
    cfg_const_en_i = 1; cfg_const_val_i = 1;
    #1 chk("R10 const high", pad_o, 1'b1);
    cfg_const_val_i = 0; data_i = 4'b0001;
    #1 chk("R10 const low", pad_o, 1'b0);
    cfg_const_en_i = 0;

    // R11 open drain
    cfg_open_drain_i = 1; data_i = 4'b0001;
    #1 chk("R11 od high released", pad_oe_o, 1'b0);
    chk("R11 od pad low", pad_o, 1'b0);
    data_i = 4'b0000;
    #1 chk("R11 od low driven", pad_oe_o, 1'b1);
    oe_i = 0;
    #1 chk("R11 oe off", pad_oe_o, 1'b0);
    oe_i = 1; cfg_open_drain_i = 0;

    // R12 async reset mid-cycle
    step();
    cfg_bypass_i = 0; data_i = 4'b0001; clk_en_i = 1;
    step(); step();
    chk("R12 loaded first", pad_o, 1'b1);
    #1 rst_ni = 0;
    #1 chk("R12 async clear", pad_o, 1'b0);
    step();
    rst_ni = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule